// File: doc/BRIEF.md
# Per-Processor Interrupt Level Combiner

This block is the per-processor slice of a multi-level interrupt system. It owns one processor's local pending word: fifteen software-raised requests, a copy of the system-wide level-15 broadcast and the state of the processor's private timer line. It folds these together with the hard-level vector that the system router has already routed and masked. The result drives the fifteen active interrupt-level lines of that processor. Level 0 does not exist and is never driven.

Software reaches the block through a small word-addressed 32-bit port. One offset reads the pending word. A second offset clears soft requests and the level-15 copy by writing ones. A third offset raises soft requests by writing ones. For the processor that the router currently targets, the readback also shows the hard levels of every pending source, whether that source is disabled or not. The router supplies zeros on that display input for every other processor.

The timer and level-15 contributions skip the per-source disables. Only the global master-disable flag can hold them back. The soft requests and the routed hard levels are not affected by that flag.

Top module: `irq_lvl_combiner`

## Requirements
- R1: After reset the pending word reads as zero and all level outputs are low.
- R2: A read at word offset 0 returns the pending word. In that word, bits 31:17 hold the soft requests, bit 15 holds the broadcast copy and bit 14 holds the timer. Display levels 15:1 are ORed into bits 15:1 of the readback, and bit 0 always reads as 0.
- R3: A write at word offset 2 sets every soft request whose bit is 1 in wdata[31:17]. Bits 16:0 of the written value are ignored.
- R4: A write at word offset 1 clears every soft request whose bit is 1 in wdata[31:17] and clears the broadcast copy when wdata[15] is 1. The timer bit and all other bits are unaffected.
- R5: Soft request bit n (17 to 31) drives level line n-16.
- R6: The timer bit copies the timer input level one cycle after it is sampled. It drives level 14 while master-disable is low.
- R7: A rising broadcast input sets bit 15 and a falling one clears it. A rise in the same cycle as a clear write leaves the bit set. Bit 15 drives level 15 while master-disable is low.
- R8: The routed hard levels 15:1 are ORed into the level outputs. Level output 0 is always low.
- R9: Master-disable suppresses only the timer and broadcast contributions. Soft and routed hard levels still reach the outputs.
- R10: Reads at offsets 1, 2 and 3 return zero. Writes at offsets 0 and 3 change nothing.
- R11: The level outputs are registered. They reflect a new pending word one cycle after the word is updated, and a change on the hard-level or master-disable input one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Word offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| timer_in | input | 1 | Local timer request level |
| bcast15_in | input | 1 | System-wide level-15 request |
| hard_lvl_in | input | 16 | Routed, masked hard levels |
| hard_disp_in | input | 16 | Unmasked hard levels for readback |
| master_dis | input | 1 | Global master disable flag |
| lvl_out | output | 16 | Registered interrupt-level lines (bit 0 unused) |

## Verification
The bench writes all ones to the set and clear offsets. A design that let the low bits through would raise or drop the timer or level-15 bits through software. It asserts the broadcast rise and a clear of bit 15 in the same cycle, which a design with the wrong priority would lose. It holds the broadcast high across a clear to show that a level-sensitive design would wrongly raise the bit again. It also runs master-disable against soft and hard levels, where a design that gated everything would silence lines that must stay up. A sample taken one cycle after a write shows whether the output register adds exactly one stage, no more and no fewer.

// File: rtl/irqlm_pkg.sv
package irqlm_pkg;
    localparam int DW        = 32;
    localparam int AW        = 2;
    localparam int NLVL      = 16;
    localparam int SOFT_LSB  = 17;
    localparam int SOFT_SHFT = 16;
    localparam int B_BCAST   = 15;
    localparam int B_TMR     = 14;

    localparam logic [DW-1:0] SOFT_MASK = {{(DW-SOFT_LSB){1'b1}}, {SOFT_LSB{1'b0}}};
    localparam logic [DW-1:0] CLR_MASK  = SOFT_MASK | (DW'(1) << B_BCAST);

    typedef enum logic [AW-1:0] {
        OFF_PEND = 2'd0,
        OFF_CLR  = 2'd1,
        OFF_SET  = 2'd2,
        OFF_NONE = 2'd3
    } acc_off_e;

    typedef struct packed {
        logic [DW-1:0] word;
        logic          bcast_prev;
    } pend_st_t;

    typedef struct packed {
        logic [NLVL-1:0] lvl;
    } lvl_st_t;
endpackage

// File: rtl/irqlm_pend.sv
module irqlm_pend
    import irqlm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          timer_in,
    input  logic          bcast_in,
    output logic [DW-1:0] pend_word
);
    pend_st_t st_d, st_q;
    logic     wr_en;

    assign wr_en = acc_valid && acc_write;

    always_comb begin
        st_d            = st_q;
        st_d.bcast_prev = bcast_in;
        if (wr_en) begin
            case (acc_off_e'(acc_addr))
                OFF_CLR: st_d.word = st_d.word & ~(acc_wdata & CLR_MASK);
                OFF_SET: st_d.word = st_d.word | (acc_wdata & SOFT_MASK);
                default: ;
            endcase
        end
        st_d.word[B_TMR] = timer_in;
        // a broadcast edge overrides a same-cycle software clear
        if (bcast_in && !st_q.bcast_prev) begin
            st_d.word[B_BCAST] = 1'b1;
        end else if (!bcast_in && st_q.bcast_prev) begin
            st_d.word[B_BCAST] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_word = st_q.word;

    // R3
    soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_addr == OFF_SET) |=>
        ((pend_word & $past(acc_wdata) & SOFT_MASK) == ($past(acc_wdata) & SOFT_MASK)));

    // R4
    soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_addr == OFF_CLR) |=>
        ((pend_word & $past(acc_wdata) & SOFT_MASK) == '0));

    // R6
    tmr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_word[B_TMR] == $past(timer_in)));

    // R7
    bcast_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(bcast_in)) |=> pend_word[B_BCAST]);
endmodule

// File: rtl/irqlm_merge.sv
module irqlm_merge
    import irqlm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   pend_word,
    input  logic [NLVL-1:0] hard_lvl_in,
    input  logic            master_dis,
    output logic [NLVL-1:0] lvl_out
);
    lvl_st_t         st_d, st_q;
    logic [NLVL-1:0] soft_lvl;
    logic [NLVL-1:0] direct_lvl;

    always_comb begin
        soft_lvl   = NLVL'(pend_word >> SOFT_SHFT);
        direct_lvl = '0;
        if (!master_dis) begin
            direct_lvl[B_BCAST] = pend_word[B_BCAST];
            direct_lvl[B_TMR]   = pend_word[B_TMR];
        end
        st_d.lvl    = hard_lvl_in | direct_lvl | soft_lvl;
        st_d.lvl[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_out = st_q.lvl;

    // R9
    mdis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_dis && !hard_lvl_in[B_TMR] && !pend_word[B_TMR + SOFT_SHFT])
        |=> !lvl_out[B_TMR]);

    // R8
    hard_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((lvl_out[NLVL-1:1] & $past(hard_lvl_in[NLVL-1:1])) == $past(hard_lvl_in[NLVL-1:1])));
endmodule

// File: rtl/irq_lvl_combiner.sv
module irq_lvl_combiner
    import irqlm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [AW-1:0]   acc_addr,
    input  logic [DW-1:0]   acc_wdata,
    output logic [DW-1:0]   acc_rdata,
    input  logic            timer_in,
    input  logic            bcast15_in,
    input  logic [NLVL-1:0] hard_lvl_in,
    input  logic [NLVL-1:0] hard_disp_in,
    input  logic            master_dis,
    output logic [NLVL-1:0] lvl_out
);
    logic [DW-1:0] pend_word;
    logic [DW-1:0] disp_word;

    irqlm_pend u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .timer_in  (timer_in),
        .bcast_in  (bcast15_in),
        .pend_word (pend_word)
    );

    irqlm_merge u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_word   (pend_word),
        .hard_lvl_in (hard_lvl_in),
        .master_dis  (master_dis),
        .lvl_out     (lvl_out)
    );

    always_comb begin
        disp_word    = DW'(hard_disp_in);
        disp_word[0] = 1'b0;
        acc_rdata    = '0;
        if (acc_valid && !acc_write && acc_addr == OFF_PEND) begin
            acc_rdata = pend_word | disp_word;
        end
    end

    // R10
    side_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr != OFF_PEND) |-> (acc_rdata == '0));

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        (!$past(rst_n)) |-> (lvl_out == '0));
endmodule

// File: tb/test_irq_lvl_combiner.sv
module test_irq_lvl_combiner;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        timer_in = 1'b0, bcast15_in = 1'b0, master_dis = 1'b0;
    logic [15:0] hard_lvl_in = '0, hard_disp_in = '0;
    logic [15:0] lvl_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_lvl_combiner i_irq_lvl_combiner (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .timer_in(timer_in), .bcast15_in(bcast15_in), .hard_lvl_in(hard_lvl_in),
        .hard_disp_in(hard_disp_in), .master_dis(master_dis), .lvl_out(lvl_out)
    );

    typedef struct {
        logic [15:0] lvl;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;
    logic [31:0] m_word = '0;

    function automatic logic [15:0] f_lvl(logic [31:0] w, logic [15:0] h, logic md);
        logic [15:0] r;
        r = (h & 16'hFFFE) | w[31:16];
        if (!md) r = r | {w[15:14], 14'b0};
        return r;
    endfunction

    function automatic logic [31:0] f_rd(logic [31:0] w, logic [15:0] d);
        return w | {16'b0, d[15:1], 1'b0};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // monitor: pops expectations and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (lvl_out !== e.lvl) begin
                n_fail++;
                $display("FAIL %s lvl_out actual=%h expected=%h", e.tag, lvl_out, e.lvl);
            end
            n_run++;
            if (acc_rdata !== e.rd) begin
                n_fail++;
                $display("FAIL %s rdata actual=%h expected=%h", e.tag, acc_rdata, e.rd);
            end
        end
    end

    task automatic expect_at(int nwait, logic [1:0] a, logic [15:0] el,
                             logic [31:0] er, string tag);
        exp_t e;
        repeat (nwait) @(posedge clk);
        #1;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        e.lvl = el; e.rd = er; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic expect_model(string tag);
        expect_at(2, 2'd0, f_lvl(m_word, hard_lvl_in, master_dis),
                  f_rd(m_word, hard_disp_in), tag);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(posedge clk);
        #1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] old_lvl;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        expect_model("R1 reset state");

        wr(2'd2, 32'hFFFF_FFFF);
        m_word = 32'hFFFE_0000;
        expect_model("R3 set ignores low bits / R5 all soft levels");

        wr(2'd1, 32'h0002_4000);
        m_word = 32'hFFFC_0000;
        expect_model("R4 clear one soft bit, timer bit ignored");

        wr(2'd1, 32'hFFFF_FFFF);
        m_word = 32'h0;
        expect_model("R4 clear all soft");

        old_lvl = f_lvl(m_word, hard_lvl_in, master_dis);
        wr(2'd2, 32'h0010_0000);
        m_word = 32'h0010_0000;
        expect_at(0, 2'd0, old_lvl, f_rd(m_word, hard_disp_in), "R11 output not yet updated");
        expect_at(0, 2'd0, 16'h0010, f_rd(m_word, hard_disp_in), "R11 R5 bit20 to level4");

        timer_in = 1'b1; m_word[14] = 1'b1;
        expect_model("R6 timer high drives level14");
        master_dis = 1'b1;
        expect_model("R9 master disable hides timer, keeps soft");
        master_dis = 1'b0; timer_in = 1'b0; m_word[14] = 1'b0;
        expect_model("R6 timer low clears bit");

        bcast15_in = 1'b1; m_word[15] = 1'b1;
        expect_model("R7 broadcast rise sets bit15");
        wr(2'd1, 32'h0000_8000); m_word[15] = 1'b0;
        expect_model("R4 clear bit15 while broadcast held high");
        bcast15_in = 1'b0;
        expect_model("R7 falling with bit already clear");
        bcast15_in = 1'b1; m_word[15] = 1'b1;
        expect_model("R7 second rise sets again");
        bcast15_in = 1'b0; m_word[15] = 1'b0;
        expect_model("R7 fall clears bit15");

        @(posedge clk);
        #1;
        bcast15_in = 1'b1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 2'd1; acc_wdata = 32'h0000_8000;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0;
        m_word[15] = 1'b1;
        expect_model("R7 rise wins over same-cycle clear");

        master_dis = 1'b1;
        expect_model("R9 master disable hides level15");
        hard_lvl_in = 16'h0A01;
        expect_model("R8 R9 hard levels pass under master disable, level0 low");
        master_dis = 1'b0;
        expect_model("R8 hard plus broadcast");

        hard_disp_in = 16'h2005;
        expect_model("R2 display levels in readback, bit0 hidden");

        expect_at(0, 2'd1, f_lvl(m_word, hard_lvl_in, master_dis), 32'h0, "R10 offset1 reads zero");
        expect_at(0, 2'd3, f_lvl(m_word, hard_lvl_in, master_dis), 32'h0, "R10 offset3 reads zero");
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFF);
        expect_model("R10 writes at offsets 3 and 0 ignored");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule